// File: doc/BRIEF.md
# Module Configuration Register with Strapped Pin Control

This block is the configuration register of a microcontroller's system integration logic. It holds one mapping bit that sets where the 4-Kbyte window of on-chip control registers is placed. The block uses that bit to decode incoming 24-bit addresses into a window-hit signal. The mapping bit starts out high after reset and can be changed only once. The first write after reset locks it, whatever value that write carries, and the lock lasts until the next reset.

The register also holds three disable bits used in single-chip operation. They gate the output enables of the instruction-tracking pins, the lowest address pins and the read/write pin. Their reset value comes from a bus-error strap input, sampled on the last clock edge of reset. A low strap selects single-chip mode, and the three bits then come out of reset set. The instruction-tracking disable applies only while the freeze input is low. Software reads all fields back through a combinational read port and can rewrite the disable bits at any time.

Top module: `modcfg_ctrl`

## Requirements
- R1: `win_hit` is high exactly when `addr[23]` equals the mapping bit and `addr[22:12]` are all ones. The window is therefore 0x7FF000–0x7FFFFF with the mapping bit at 0 and 0xFFF000–0xFFFFFF with the bit at 1, and `win_hit` follows `addr` in the same cycle.
- R2: The mapping bit sits at `rd_data[3]` and is 1 after reset. The first write after reset loads it from `wr_data[3]`, and every later write leaves it unchanged until reset is applied again.
- R3: The first write after reset locks the mapping bit even when it writes the value the bit already holds.
- R4: The instruction-tracking disable bit sits at `rd_data[2]`. While it is 1 and `freeze` is 0, every bit of `trk_oe` is 0. While it is 0, or while `freeze` is 1, every bit of `trk_oe` is 1.
- R5: The low-address disable bit sits at `rd_data[1]`. Every bit of `addr_lo_oe` is the inverse of this bit.
- R6: The read/write disable bit sits at `rd_data[0]`. `rw_oe` is the inverse of this bit.
- R7: Each clock edge with `rst_n` low loads all three disable bits with the inverse of `berr_strap`, so a low strap gives 1 and a high strap gives 0. The same edge sets the mapping bit to 1.
- R8: `rd_data` shows the current field values at bits 3:0, with bits 15:4 reading 0.
- R9: Every write loads the three disable bits from `wr_data[2:0]`, however many writes came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| berr_strap | input | 1 | Bus-error strap, sampled while in reset |
| freeze | input | 1 | Debug freeze indication |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| addr | input | 24 | Address to decode against the window |
| win_hit | output | 1 | Address falls in the control register window |
| trk_oe | output | 2 | Output enables of the instruction-tracking pins |
| addr_lo_oe | output | 3 | Output enables of the lowest address pins |
| rw_oe | output | 1 | Output enable of the read/write pin |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 4-Kbyte window, two tracking pins and three low address pins. These values put both window bases within reach, including the edges on either side of each, such as 0xFFEFFF against 0xFFF000. The bench resets the block under both strap levels. It checks the lock with a first write that changes the mapping bit and with a first write that leaves it unchanged. It also drives freeze both ways while the tracking disable bit is set.

// File: rtl/mcr_pkg.sv
// Shared field layout of the module configuration register.
// Assumes a register of at least four bits; the upper bits read as zero.
package mcr_pkg;
    localparam int RW_DIS_POS  = 0;
    localparam int ALO_DIS_POS = 1;
    localparam int TRK_DIS_POS = 2;
    localparam int MAP_POS     = 3;
    localparam int FIELD_W     = 4;

    // Packed so that each member sits at its bit position above.
    typedef struct packed {
        logic map_hi;
        logic trk_dis;
        logic alo_dis;
        logic rw_dis;
    } ctl_fields_t;
endpackage

// File: rtl/mcr_reg_core.sv
// Register storage: a mapping bit that can be written once and three
// disable bits whose reset value comes from the strap.
// Assumes a synchronous active-low reset and REG_W >= FIELD_W.
module mcr_reg_core
    import mcr_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             berr_strap,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_fields_t      fields,
    output logic [REG_W-1:0] rd_data
);
    localparam int HI_W = REG_W - FIELD_W;

    logic map_locked;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:FIELD_W];

    // Mapping bit with lock: reset sets it, only the first write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields.map_hi <= 1'b1;
            map_locked    <= 1'b0;
        end else if (wr_en) begin
            if (!map_locked) begin
                fields.map_hi <= wr_data[MAP_POS];
            end
            map_locked <= 1'b1;
        end
    end

    // Disable bits: loaded from the inverted strap in reset, rewritable afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields.trk_dis <= ~berr_strap;
            fields.alo_dis <= ~berr_strap;
            fields.rw_dis  <= ~berr_strap;
        end else if (wr_en) begin
            fields.trk_dis <= wr_data[TRK_DIS_POS];
            fields.alo_dis <= wr_data[ALO_DIS_POS];
            fields.rw_dis  <= wr_data[RW_DIS_POS];
        end
    end

    // Read view: fields in the low bits, zeros above.
    always_comb begin
        rd_data = {{HI_W{1'b0}}, fields};
    end
endmodule

// File: rtl/mcr_win_decode.sv
// Window decoder: the mapping bit acts as the top address bit, and the
// bits between it and the window offset must all be ones.
// Assumes ADDR_W > WIN_AW + 1.
module mcr_win_decode #(
    parameter int ADDR_W = 24,
    parameter int WIN_AW = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_hi,
    output logic              hit
);
    localparam int MID_W = ADDR_W - 1 - WIN_AW;

    logic [MID_W-1:0] mid_bits;
    logic             unused_offset;

    assign mid_bits      = addr[ADDR_W-2:WIN_AW];
    assign unused_offset = ^addr[WIN_AW-1:0];

    // Compare the top bit with the mapping bit and require all-ones between.
    always_comb begin
        hit = (addr[ADDR_W-1] == map_hi) && (&mid_bits);
    end
endmodule

// File: rtl/mcr_pin_oe.sv
// Pin output-enable control for the tracking, low-address and read/write pins.
// Assumes enables are active high; a set disable bit tri-states the pins.
module mcr_pin_oe #(
    parameter int TRK_N = 2,
    parameter int ALO_N = 3
) (
    input  logic             freeze,
    input  logic             trk_dis,
    input  logic             alo_dis,
    input  logic             rw_dis,
    output logic [TRK_N-1:0] trk_oe,
    output logic [ALO_N-1:0] alo_oe,
    output logic             rw_oe
);
    logic trk_off;

    // The tracking disable applies only outside freeze.
    always_comb begin
        trk_off = trk_dis & ~freeze;
    end

    genvar gi;
    generate
        for (gi = 0; gi < TRK_N; gi++) begin : g_trk
            assign trk_oe[gi] = ~trk_off;
        end
        for (gi = 0; gi < ALO_N; gi++) begin : g_alo
            assign alo_oe[gi] = ~alo_dis;
        end
    endgenerate

    // Single read/write pin.
    always_comb begin
        rw_oe = ~rw_dis;
    end
endmodule

// File: rtl/modcfg_ctrl.sv
// Top level of the module configuration register: storage, window decode
// and pin enables. Assumes a single clock and a synchronous active-low reset.
module modcfg_ctrl
    import mcr_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 24,
    parameter int WIN_AW = 12,
    parameter int TRK_N  = 2,
    parameter int ALO_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              berr_strap,
    input  logic              freeze,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit,
    output logic [TRK_N-1:0]  trk_oe,
    output logic [ALO_N-1:0]  addr_lo_oe,
    output logic              rw_oe
);
    ctl_fields_t fields;

    mcr_reg_core #(.REG_W(REG_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .berr_strap (berr_strap),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .fields     (fields),
        .rd_data    (rd_data)
    );

    mcr_win_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
        .addr   (addr),
        .map_hi (fields.map_hi),
        .hit    (win_hit)
    );

    mcr_pin_oe #(.TRK_N(TRK_N), .ALO_N(ALO_N)) u_oe (
        .freeze  (freeze),
        .trk_dis (fields.trk_dis),
        .alo_dis (fields.alo_dis),
        .rw_dis  (fields.rw_dis),
        .trk_oe  (trk_oe),
        .alo_oe  (addr_lo_oe),
        .rw_oe   (rw_oe)
    );
endmodule

// File: rtl/modcfg_ctrl_chk.sv
// Assertion checker for modcfg_ctrl, attached through bind.
// Watches only the ports and keeps its own record of writes since reset.
module modcfg_ctrl_chk
    import mcr_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 24,
    parameter int TRK_N  = 2,
    parameter int ALO_N  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              berr_strap,
    input logic              freeze,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic [ADDR_W-1:0] addr,
    input logic              win_hit,
    input logic [TRK_N-1:0]  trk_oe,
    input logic [ALO_N-1:0]  addr_lo_oe,
    input logic              rw_oe
);
    logic wrote_q;

    // Records whether any write has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wrote_q <= 1'b0;
        else if (wr_en) wrote_q <= 1'b1;
    end

    p_hit_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (addr[ADDR_W-1] == rd_data[MAP_POS]));

    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrote_q && wr_en) |=> (rd_data[MAP_POS] == $past(wr_data[MAP_POS])));

    p_map_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrote_q |=> $stable(rd_data[MAP_POS]));

    p_trk_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[TRK_DIS_POS] && !freeze) |-> (trk_oe == '0));

    p_trk_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[TRK_DIS_POS] || freeze) |-> (&trk_oe));

    p_alo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ALO_DIS_POS] |-> (addr_lo_oe == '0));

    p_rw_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RW_DIS_POS] |-> !rw_oe);

    p_strap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data[MAP_POS] &&
            (rd_data[TRK_DIS_POS:RW_DIS_POS] == {3{~$past(berr_strap)}})));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FIELD_W] == '0);

    p_dis_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[TRK_DIS_POS:RW_DIS_POS] ==
                   $past(wr_data[TRK_DIS_POS:RW_DIS_POS])));
endmodule

bind modcfg_ctrl modcfg_ctrl_chk #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .TRK_N(TRK_N), .ALO_N(ALO_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .berr_strap(berr_strap), .freeze(freeze),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .addr(addr),
    .win_hit(win_hit), .trk_oe(trk_oe), .addr_lo_oe(addr_lo_oe), .rw_oe(rw_oe)
);

// File: tb/modcfg_ctrl_test.sv
// Bench for modcfg_ctrl: a behavioural model updated on every rising edge
// and compared with every output on every falling edge, plus directed checks.
module modcfg_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        berr_strap = 1'b0;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [23:0] addr = '0;
    logic [15:0] rd_data;
    logic        win_hit;
    logic [1:0]  trk_oe;
    logic [2:0]  addr_lo_oe;
    logic        rw_oe;

    int checks = 0;
    int errors = 0;

    // Model state
    bit m_map = 1'b1, m_lock = 1'b0, m_trk = 1'b1, m_alo = 1'b1, m_rw = 1'b1;

    always #10 clk = ~clk;

    modcfg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .berr_strap(berr_strap), .freeze(freeze),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .addr(addr),
        .win_hit(win_hit), .trk_oe(trk_oe), .addr_lo_oe(addr_lo_oe), .rw_oe(rw_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_map = 1'b1; m_lock = 1'b0;
            m_trk = !berr_strap; m_alo = !berr_strap; m_rw = !berr_strap;
        end else if (wr_en) begin
            if (!m_lock) m_map = wr_data[3];
            m_lock = 1'b1;
            m_trk = wr_data[2]; m_alo = wr_data[1]; m_rw = wr_data[0];
        end
    end

    // Compare all outputs on each falling edge.
    always @(negedge clk) begin
        bit exp_hit;
        exp_hit = (addr[23] == m_map) && (addr[22:12] == 11'h7FF);
        chk("R8 rd_data", rd_data, {12'h0, m_map, m_trk, m_alo, m_rw});
        chk("R1 win_hit", win_hit, exp_hit);
        chk("R4 trk_oe", trk_oe, (m_trk && !freeze) ? 2'b00 : 2'b11);
        chk("R5 addr_lo_oe", addr_lo_oe, m_alo ? 3'b000 : 3'b111);
        chk("R6 rw_oe", rw_oe, !m_rw);
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; berr_strap = strap; step(); step();
        berr_strap = ~strap; rst_n = 1'b1; step();
    endtask

    task automatic probe(input string tag, input logic [23:0] a, input logic exp);
        addr = a; #1; chk(tag, win_hit, exp);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        // R7: low strap gives single-chip reset values; strap flips after release
        do_reset(1'b0);
        chk("R7 reset low strap", rd_data, 16'h000F);
        chk("R6 rw tri-stated", rw_oe, 1'b0);
        // R1: upper window
        probe("R1 FFF000", 24'hFFF000, 1'b1);
        probe("R1 FFFFFF", 24'hFFFFFF, 1'b1);
        probe("R1 FFEFFF", 24'hFFEFFF, 1'b0);
        probe("R1 7FF000", 24'h7FF000, 1'b0);
        // R4: freeze re-enables tracking pins
        freeze = 1'b1; #1; chk("R4 freeze on", trk_oe, 2'b11);
        freeze = 1'b0; #1; chk("R4 freeze off", trk_oe, 2'b00);
        step();
        // R2: first write moves window low
        wr(16'hFFF0);
        chk("R2 first write", rd_data, 16'h0000);
        probe("R1 low 7FF000", 24'h7FF000, 1'b1);
        probe("R1 low 7FFFFF", 24'h7FFFFF, 1'b1);
        probe("R1 low 7FEFFF", 24'h7FEFFF, 1'b0);
        probe("R1 low FFF000", 24'hFFF000, 1'b0);
        // R2 and R9: later write ignored for map, disable bits updated
        wr(16'h000D);
        chk("R2 map locked", rd_data[3], 1'b0);
        chk("R9 disable bits", rd_data[2:0], 3'b101);
        chk("R5 alo enabled", addr_lo_oe, 3'b111);
        wr(16'h0002);
        chk("R9 rewrite", rd_data, 16'h0002);
        // R7: high strap clears disable bits, restores map
        do_reset(1'b1);
        chk("R7 reset high strap", rd_data, 16'h0008);
        chk("R4 trk enabled", trk_oe, 2'b11);
        // R3: first write that keeps map at 1 still locks
        wr(16'h0008);
        wr(16'h0000);
        chk("R3 lock on same value", rd_data[3], 1'b1);
        probe("R3 window stays high", 24'hFFF123, 1'b1);
        step(); step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule